// File: doc/BRIEF.md
# Virtual Pending-Table Base Register Controller

This block holds the 64-bit register through which software schedules and deschedules a virtual CPU on an interrupt redistributor. The register carries the pending-table physical address, cache and shareability attributes, an implementation-defined-area hint bit, a PendingLast status bit, a read-only Dirty bit and the VALID bit. Writes arrive as either 32-bit half writes or full 64-bit writes; a half write is first merged with the other half of the current value. The merged value is then judged by how it changes VALID.

Setting VALID schedules the virtual CPU: the block forces PendingLast to 1 and sends a one-cycle request to an external table scanner. The scanner answers with a done strobe and an 8-bit priority, which becomes the best pending priority. Until the answer arrives, the write port reports not-ready and accepts nothing. Clearing VALID deschedules: PendingLast records whether anything was pending, and the best pending priority returns to the idle value 0xFF. A write that keeps VALID at 1 changes nothing; if it tried to alter any bit, an error strobe is raised.

Top module: `vpend_base_ctrl`

## Requirements
- R1: After reset the register reads 0, the best pending priority is 0xFF, the write port is ready, and the scan request and error strobes are low.
- R2: Only the writable fields are stored: VALID (bit 63), IDAI (bit 62), PendingLast (bit 61), outer cache (58:56), physical address (51:16), shareability (11:10) and inner cache (9:7). Dirty (bit 60) and all other bits always read 0.
- R3: Write-lane select bit 0 writes bits 31:0, bit 1 writes bits 63:32, and both together write all 64 bits. Unselected lanes keep their current value before the VALID checks are applied. A write with no lane selected has no effect.
- R4: A write whose merged value has VALID at 0 while VALID was 0 stores the merged value as written, including PendingLast. It requests no scan and leaves the best pending priority unchanged.
- R5: A write that takes VALID from 0 to 1 stores the merged value with PendingLast forced to 1. It also raises the scan request for exactly the one cycle after the write.
- R6: From the write that requests a scan until the cycle with scan_done high, the write port is not ready and writes are ignored. On scan_done the scan priority becomes the best pending priority and the port is ready again.
- R7: A write that takes VALID from 1 to 0 stores the merged value with PendingLast set to 1 if the best pending priority was not 0xFF, and 0 otherwise. The best pending priority becomes 0xFF.
- R8: A write whose merged value keeps VALID at 1 while VALID was 1 leaves the register unchanged. The error strobe is high for the one cycle after it exactly when the merged value differs from the current value.
- R9: scan_done while no scan is outstanding has no effect on the best pending priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, taken when wr_ready is high |
| wr_lanes | input | 2 | Lane select: bit 0 low word, bit 1 high word |
| wr_data | input | 64 | Write data in its final bit positions |
| wr_ready | output | 1 | Low while a table scan is outstanding |
| rd_data | output | 64 | Current register value |
| best_prio | output | 8 | Best pending virtual priority, 0xFF when idle |
| scan_req | output | 1 | One-cycle rescan request |
| scan_done | input | 1 | Scanner completion strobe |
| scan_prio | input | 8 | Priority found by the scanner |
| err_evt | output | 1 | One-cycle strobe for a refused change while VALID is 1 |

## Verification
Every result is registered. The new register value, scan_req, err_evt and the drop of wr_ready all appear one clock edge after the edge that takes the write. The new best_prio and the return of wr_ready appear one edge after the edge that samples scan_done. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and compares every output against its own model at the next falling edge. scan_req and err_evt are checked at the falling edge where they must be high, and again after the following operation, where they must have dropped.

// File: rtl/vpend_base_ctrl.sv
module vpend_base_ctrl #(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_lanes,
  input  logic [63:0]       wr_data,
  output logic              wr_ready,
  output logic [63:0]       rd_data,
  output logic [PRIO_W-1:0] best_prio,
  output logic              scan_req,
  input  logic              scan_done,
  input  logic [PRIO_W-1:0] scan_prio,
  output logic              err_evt
);
  localparam int VLD_B = 63;
  localparam int PLAST_B = 61;
  localparam logic [PRIO_W-1:0] IDLE = '1;
  localparam logic [63:0] KEEP =
      (64'd1 << 63) | (64'd1 << 62) | (64'd1 << 61) | (64'h7 << 56) |
      (((64'd1 << 36) - 64'd1) << 16) | (64'h3 << 10) | (64'h7 << 7);

  logic [63:0] base_q;
  logic [PRIO_W-1:0] prio_q;
  logic busy_q, req_q, err_q;

  logic [63:0] lane_m, merged;
  logic take, old_v, new_v;

  assign lane_m = {{32{wr_lanes[1]}}, {32{wr_lanes[0]}}};
  assign merged = ((base_q & ~lane_m) | (wr_data & lane_m)) & KEEP;
  assign take   = wr_en && !busy_q && (wr_lanes != 2'b00);
  assign old_v  = base_q[VLD_B];
  assign new_v  = merged[VLD_B];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      prio_q <= IDLE;
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      req_q <= 1'b0;
      err_q <= 1'b0;
      if (take) begin
        unique case ({old_v, new_v})
          2'b00: base_q <= merged;
          2'b01: begin
            base_q <= merged | (64'd1 << PLAST_B);
            req_q  <= 1'b1;
            busy_q <= 1'b1;
          end
          2'b10: begin
            base_q          <= merged;
            base_q[PLAST_B] <= (prio_q != IDLE);
            prio_q          <= IDLE;
          end
          default: err_q <= (merged != base_q);
        endcase
      end
      if (busy_q && scan_done) begin
        prio_q <= scan_prio;
        busy_q <= 1'b0;
      end
    end
  end

  assign wr_ready  = !busy_q;
  assign rd_data   = base_q;
  assign best_prio = prio_q;
  assign scan_req  = req_q;
  assign err_evt   = err_q;
endmodule

module vpend_base_ctrl_chk #(
  parameter int PRIO_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_ready,
  input logic [63:0]       rd_data,
  input logic [PRIO_W-1:0] best_prio,
  input logic              scan_req,
  input logic              err_evt
);
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_req |=> !scan_req); // R5
  AST_SCHED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[63]) |-> (scan_req && rd_data[61])); // R5
  AST_REQ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    scan_req |-> !wr_ready); // R6
  AST_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> $stable(rd_data)); // R6
  AST_DESCHED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[63]) |-> (best_prio == '1)); // R7
  AST_ERR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> (rd_data[63] && $stable(rd_data))); // R8
endmodule

bind vpend_base_ctrl vpend_base_ctrl_chk #(.PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .rd_data(rd_data),
  .best_prio(best_prio), .scan_req(scan_req), .err_evt(err_evt)
);

// File: tb/vpend_base_ctrl_test.sv
`timescale 1ns/1ps
module vpend_base_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_lanes = 2'b00;
  logic [63:0] wr_data = '0;
  logic scan_done = 1'b0;
  logic [7:0] scan_prio = '0;
  logic wr_ready, scan_req, err_evt;
  logic [63:0] rd_data;
  logic [7:0] best_prio;

  always #2.5 clk = ~clk;

  vpend_base_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lanes(wr_lanes),
    .wr_data(wr_data), .wr_ready(wr_ready), .rd_data(rd_data),
    .best_prio(best_prio), .scan_req(scan_req), .scan_done(scan_done),
    .scan_prio(scan_prio), .err_evt(err_evt)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic [63:0] m_reg;
  logic [7:0] m_prio;
  bit m_busy, e_req, e_err;

  function automatic logic [63:0] fmask();
    logic [63:0] m = '0;
    m[63] = 1; m[62] = 1; m[61] = 1; m[58:56] = '1;
    m[51:16] = '1; m[11:10] = '1; m[9:7] = '1;
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(rd_data == m_reg, {tag, " rd_data"}, rd_data, m_reg);
    chk(best_prio == m_prio, {tag, " best_prio"}, 64'(best_prio), 64'(m_prio));
    chk(scan_req == e_req, {tag, " scan_req"}, 64'(scan_req), 64'(e_req));
    chk(err_evt == e_err, {tag, " err_evt"}, 64'(err_evt), 64'(e_err));
    chk(wr_ready == !m_busy, {tag, " wr_ready"}, 64'(wr_ready), 64'(!m_busy));
  endtask

  task automatic model_write(input logic [1:0] ln, input logic [63:0] d);
    logic [63:0] lm, mg;
    e_req = 0; e_err = 0;
    if (m_busy || ln == 2'b00) return;
    lm = {{32{ln[1]}}, {32{ln[0]}}};
    mg = ((m_reg & ~lm) | (d & lm)) & fmask();
    if (!m_reg[63] && !mg[63]) m_reg = mg;
    else if (!m_reg[63] && mg[63]) begin
      mg[61] = 1; m_reg = mg; e_req = 1; m_busy = 1;
    end else if (m_reg[63] && !mg[63]) begin
      mg[61] = (m_prio != 8'hFF); m_reg = mg; m_prio = 8'hFF;
    end else e_err = (mg != m_reg);
  endtask

  task automatic wr(input logic [1:0] ln, input logic [63:0] d, input string tag);
    wr_en = 1; wr_lanes = ln; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0; wr_lanes = 2'b00;
    model_write(ln, d);
    check_all(tag);
  endtask

  task automatic done(input logic [7:0] p, input string tag);
    scan_done = 1; scan_prio = p;
    @(posedge clk); @(negedge clk);
    scan_done = 0;
    e_req = 0; e_err = 0;
    if (m_busy) begin m_prio = p; m_busy = 0; end
    check_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_reg = '0; m_prio = 8'hFF; m_busy = 0; e_req = 0; e_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");

    // R2 / R3: high lane all-but-VALID, then low lane ones
    wr(2'b10, 64'h7FFF_FFFF_0000_0000, "R2 R3 high lane");
    chk(rd_data[60] == 0, "R2 dirty reads 0", 64'(rd_data[60]), 64'd0);
    wr(2'b01, 64'h0000_0000_FFFF_FFFF, "R2 R3 low lane");
    wr(2'b00, 64'hFFFF_FFFF_FFFF_FFFF, "R3 no lane");
    // R4: 0->0 full write with PendingLast clear
    wr(2'b11, 64'h0000_1234_5678_0480, "R4 idle store");
    // R5 schedule via high lane only
    wr(2'b10, 64'h8000_0000_0000_0000, "R5 schedule");
    chk(rd_data[61] == 1, "R5 pendinglast forced", 64'(rd_data[61]), 64'd1);
    // R6 stalled write
    wr(2'b11, 64'h0, "R6 write while busy");
    done(8'h40, "R6 scan done");
    // R8 identical write, then altering write
    wr(2'b11, m_reg, "R8 same value");
    wr(2'b01, 64'h0000_0000_0000_0C00, "R8 change refused");
    // R9 stray done
    done(8'h11, "R9 stray done");
    // R7 deschedule with pending
    wr(2'b10, 64'h0000_0000_0000_0000, "R7 desched pending");
    chk(rd_data[61] == 1, "R7 pendinglast set", 64'(rd_data[61]), 64'd1);
    // R7 deschedule with nothing pending
    wr(2'b11, 64'h8000_0000_0001_0000, "R5 reschedule");
    done(8'hFF, "R6 done idle prio");
    wr(2'b11, 64'h2000_0000_0001_0000, "R7 desched idle");
    chk(rd_data[61] == 0, "R7 pendinglast clear", 64'(rd_data[61]), 64'd0);

    for (int i = 0; i < 400; i++) begin
      int r = $urandom % 10;
      logic [63:0] d = {$urandom, $urandom};
      logic [1:0] ln = 2'($urandom % 4);
      if (m_busy && r < 6) done(($urandom % 4 == 0) ? 8'hFF : 8'($urandom), "R6 random done");
      else if (r == 9) done(8'($urandom), "R9 random stray");
      else if (r == 8) wr(ln, m_reg, "R8 random rewrite");
      else wr(ln, d, "R4 R5 R7 R8 random write");
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule